// File: doc/BRIEF.md
# SPI Event and Interrupt Controller

This block sits beside an SPI master's transfer engine and turns the engine's one-cycle event pulses into nine sticky event flags. Software reads the flags through a small register port and acknowledges them by writing ones. A mask register chooses which flags may raise the single interrupt line. The block also sorts the pending flags into two summary outputs. One reports that an error flag is pending. The other reports that the transfer completed cleanly.

The same register port carries three command bits. The start bit produces a one-cycle start strobe to the engine. The two FIFO-clear bits each run a short sequence: the bit reads back as one while the clear is in progress, and then the block emits a one-cycle flush strobe toward that FIFO. A read-only status word reflects the engine's ready and FIFO flags together with the interrupt state. The FIFOs and the shifter are outside this block. Register writes are always accepted in the cycle they are presented, so the port has no back-pressure. The read path is combinational from the address.

Top module: `spi_evt_ctrl`

## Requirements
- R1: After reset, every event flag is 0, every mask bit is 1 (mask reads 0x01FF), the command register reads 0, and irq, err_pending, done_ok, start_pulse, rx_flush and tx_flush are all 0.
- R2: A 1 on evt_pulse[i] at a clock edge sets event flag i, readable at register address 2 from the next cycle. The flag stays set until software clears it. Flag order from bit 0 upward: master done, slave done, TX request, TX overflow, TX underflow, RX request, RX overflow, RX underflow, multi-master error.
- R3: A write to address 2 clears exactly the flags whose write-data bit is 1 and leaves the other flags unchanged. Writing 0x1FF clears every flag.
- R4: If an event pulse arrives in the same cycle as a write that clears the same flag, the flag stays set.
- R5: irq is 1 exactly when some flag is set while its mask bit is 0. The interrupt bit of the status word (bit 2) equals irq.
- R6: The mask register at address 1 takes write-data bits [8:0] and reads them back. A masked event is still recorded in the event register, but it does not raise irq.
- R7: Writing 1 to command bit 1 (RX clear) or command bit 2 (TX clear) at address 0 makes that bit read 1 for exactly two cycles. In the following cycle the bit reads 0 and rx_flush or tx_flush, respectively, is 1 for that single cycle.
- R8: A write to a FIFO-clear bit while that bit's sequence is still running is ignored. The sequence neither restarts nor lengthens.
- R9: Writing 1 to command bit 0 produces start_pulse for the one cycle after the write. Command bit 0 always reads 0.
- R10: The status word at address 3 has these bits: bit 0 device ready, bit 1 subsystem ready, bit 2 interrupt pending, bit 3 TX FIFO full, bit 4 RX FIFO empty. All other bits are 0.
- R11: err_pending is 1 while any of these flags is set, regardless of the mask: slave done, TX overflow, TX underflow, RX overflow, RX underflow, multi-master error. done_ok is 1 while the master-done flag is set and err_pending is 0.
- R12: A write to address 3 has no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 mask, 2 events, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| evt_pulse | input | 9 | Event pulses from the transfer engine |
| dev_ready | input | 1 | Engine ready flag |
| subsys_ready | input | 1 | Subsystem ready flag |
| txf_full | input | 1 | TX FIFO full flag |
| rxf_empty | input | 1 | RX FIFO empty flag |
| irq | output | 1 | Interrupt request |
| err_pending | output | 1 | Some error flag is set |
| done_ok | output | 1 | Master done is set and no error is set |
| start_pulse | output | 1 | One-cycle transfer start strobe |
| rx_flush | output | 1 | One-cycle RX FIFO flush strobe |
| tx_flush | output | 1 | One-cycle TX FIFO flush strobe |

## Verification
A pulse or a register write that is presented before edge k changes its flag, mask or command state one cycle later, just after edge k. The irq, err_pending, done_ok and status outputs follow that state in the same cycle. A FIFO-clear bit reads 1 after edges k and k+1. After edge k+2 it reads 0 and its flush strobe is 1. The bench advances a behavioural model on each rising edge, using the inputs that are held over that edge. It compares every output and the read data at the following falling edge, which is the first settled point after the expected change.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int unsigned NEV = 9;

  typedef enum logic [1:0] {
    A_CMD    = 2'd0,
    A_MASK   = 2'd1,
    A_EVENT  = 2'd2,
    A_STATUS = 2'd3
  } reg_sel_e;

  // event flag positions
  localparam int unsigned EV_MDONE = 0;
  localparam int unsigned EV_SDONE = 1;
  localparam int unsigned EV_TXREQ = 2;
  localparam int unsigned EV_TXOVF = 3;
  localparam int unsigned EV_TXUDF = 4;
  localparam int unsigned EV_RXREQ = 5;
  localparam int unsigned EV_RXOVF = 6;
  localparam int unsigned EV_RXUDF = 7;
  localparam int unsigned EV_MMERR = 8;

  localparam logic [NEV-1:0] ERR_SET =
    (NEV'(1) << EV_SDONE) | (NEV'(1) << EV_TXOVF) | (NEV'(1) << EV_TXUDF) |
    (NEV'(1) << EV_RXOVF) | (NEV'(1) << EV_RXUDF) | (NEV'(1) << EV_MMERR);

  // command bit positions
  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_RXCLR = 1;
  localparam int unsigned CB_TXCLR = 2;
endpackage

// File: rtl/spi_evt_bank.sv
module spi_evt_bank
  import spi_evt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] pulse,
  input  logic [NEV-1:0] clr,
  input  logic           mask_we,
  input  logic [NEV-1:0] mask_d,
  output logic [NEV-1:0] ev,
  output logic [NEV-1:0] mask,
  output logic           irq
);
  for (genvar i = 0; i < NEV; i++) begin : g_bit
    logic ev_b;
    logic mk_b;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ev_b <= 1'b0;
        mk_b <= 1'b1;
      end else begin
        if (pulse[i])      ev_b <= 1'b1;   // set wins over clear
        else if (clr[i])   ev_b <= 1'b0;
        if (mask_we)       mk_b <= mask_d[i];
      end
    end
    assign ev[i]   = ev_b;
    assign mask[i] = mk_b;
  end

  assign irq = |(ev & ~mask);
endmodule

// File: rtl/spi_fifo_clr_seq.sv
module spi_fifo_clr_seq #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic flush
);
  localparam int unsigned AW = $clog2(HOLD + 1);
  localparam logic [AW-1:0] LAST = AW'(HOLD - 1);

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      flush <= 1'b0;
      age   <= '0;
    end else begin
      flush <= 1'b0;
      if (busy) begin
        if (age == LAST) begin
          busy  <= 1'b0;
          flush <= 1'b1;
        end else begin
          age <= age + 1'b1;
        end
      end else if (go) begin
        busy <= 1'b1;
        age  <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_evt_ctrl.sv
module spi_evt_ctrl
  import spi_evt_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned CLR_HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [8:0]    evt_pulse,
  input  logic          dev_ready,
  input  logic          subsys_ready,
  input  logic          txf_full,
  input  logic          rxf_empty,
  output logic          irq,
  output logic          err_pending,
  output logic          done_ok,
  output logic          start_pulse,
  output logic          rx_flush,
  output logic          tx_flush
);
  logic wr_cmd, wr_mask, wr_evt;
  logic [NEV-1:0] ev_w, mask_w, clr_w;
  logic rx_busy, tx_busy;
  logic [4:0] stat_w;

  assign wr_cmd  = reg_wr && (reg_addr == A_CMD);
  assign wr_mask = reg_wr && (reg_addr == A_MASK);
  assign wr_evt  = reg_wr && (reg_addr == A_EVENT);
  assign clr_w   = wr_evt ? reg_wdata[NEV-1:0] : '0;

  spi_evt_bank u_bank (
    .clk(clk), .rst_n(rst_n), .pulse(evt_pulse), .clr(clr_w),
    .mask_we(wr_mask), .mask_d(reg_wdata[NEV-1:0]),
    .ev(ev_w), .mask(mask_w), .irq(irq)
  );

  spi_fifo_clr_seq #(.HOLD(CLR_HOLD)) u_rxclr (
    .clk(clk), .rst_n(rst_n), .go(wr_cmd && reg_wdata[CB_RXCLR]),
    .busy(rx_busy), .flush(rx_flush)
  );

  spi_fifo_clr_seq #(.HOLD(CLR_HOLD)) u_txclr (
    .clk(clk), .rst_n(rst_n), .go(wr_cmd && reg_wdata[CB_TXCLR]),
    .busy(tx_busy), .flush(tx_flush)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) start_pulse <= 1'b0;
    else        start_pulse <= wr_cmd && reg_wdata[CB_START];
  end

  assign err_pending = |(ev_w & ERR_SET);
  assign done_ok     = ev_w[EV_MDONE] && !err_pending;
  assign stat_w      = {rxf_empty, txf_full, irq, subsys_ready, dev_ready};

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CMD: begin
        reg_rdata[CB_RXCLR] = rx_busy;
        reg_rdata[CB_TXCLR] = tx_busy;
      end
      A_MASK:   reg_rdata[NEV-1:0] = mask_w;
      A_EVENT:  reg_rdata[NEV-1:0] = ev_w;
      A_STATUS: reg_rdata[4:0]     = stat_w;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_evt_ctrl_chk.sv
module spi_evt_ctrl_chk
  import spi_evt_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [8:0]    evt_pulse,
  input logic [8:0]    ev,
  input logic [8:0]    mask,
  input logic          irq,
  input logic          err_pending,
  input logic          done_ok,
  input logic          start_pulse,
  input logic          rx_busy,
  input logic          tx_busy,
  input logic          rx_flush,
  input logic          tx_flush
);
  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev & $past(evt_pulse)) == $past(evt_pulse))); // R4
  AST_EVT_NO_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev & ~$past(ev) & ~$past(evt_pulse)) == 9'd0)); // R2
  AST_EVT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_EVENT) |=>
      ((ev & $past(reg_wdata[8:0]) & ~$past(evt_pulse)) == 9'd0)); // R3
  AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ev & ~mask) != 9'd0)); // R5
  AST_STAT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STATUS) |-> (reg_rdata[2] == irq)); // R5
  AST_RXFL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !rx_flush); // R7
  AST_TXFL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> !tx_flush); // R7
  AST_RXFL_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> (!rx_busy && $past(rx_busy))); // R7
  AST_TXFL_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |-> (!tx_busy && $past(tx_busy))); // R7
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(reg_wr && reg_addr == A_CMD && reg_wdata[0])); // R9
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> !err_pending); // R11
endmodule

bind spi_evt_ctrl spi_evt_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
  .ev(ev_w), .mask(mask_w), .irq(irq), .err_pending(err_pending),
  .done_ok(done_ok), .start_pulse(start_pulse), .rx_busy(rx_busy),
  .tx_busy(tx_busy), .rx_flush(rx_flush), .tx_flush(tx_flush)
);

// File: tb/test_spi_evt_ctrl.sv
`timescale 1ns/1ps
module test_spi_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [8:0]  evt_pulse = 9'd0;
  logic dev_ready = 1'b0, subsys_ready = 1'b0, txf_full = 1'b0, rxf_empty = 1'b0;
  logic irq, err_pending, done_ok, start_pulse, rx_flush, tx_flush;

  always #10 clk = ~clk;

  spi_evt_ctrl i_spi_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .dev_ready(dev_ready), .subsys_ready(subsys_ready), .txf_full(txf_full),
    .rxf_empty(rxf_empty), .irq(irq), .err_pending(err_pending),
    .done_ok(done_ok), .start_pulse(start_pulse), .rx_flush(rx_flush),
    .tx_flush(tx_flush)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  // behavioural reference model
  int m_ev, m_mask, m_rxcnt, m_txcnt;
  bit m_rxfl, m_txfl, m_start;
  localparam int ERRS = 'h1DA;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ev = 0; m_mask = 'h1FF; m_rxcnt = 0; m_txcnt = 0;
      m_rxfl = 0; m_txfl = 0; m_start = 0;
    end else begin
      int clr;
      bit cw;
      cw  = reg_wr && reg_addr == 2'd0;
      clr = (reg_wr && reg_addr == 2'd2) ? int'(reg_wdata[8:0]) : 0;
      m_ev = (m_ev & ~clr & 'h1FF) | int'(evt_pulse);
      if (reg_wr && reg_addr == 2'd1) m_mask = int'(reg_wdata[8:0]);
      m_start = cw && reg_wdata[0];
      if (m_rxcnt != 0) begin m_rxcnt--; m_rxfl = (m_rxcnt == 0); end
      else begin m_rxfl = 0; if (cw && reg_wdata[1]) m_rxcnt = 2; end
      if (m_txcnt != 0) begin m_txcnt--; m_txfl = (m_txcnt == 0); end
      else begin m_txfl = 0; if (cw && reg_wdata[2]) m_txcnt = 2; end
    end
  end

  task automatic cmp(input string sig, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s/%s got 0x%0h exp 0x%0h at %0t", phase, sig, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    int e_irq, e_err, e_rd;
    e_irq = ((m_ev & ~m_mask & 'h1FF) != 0) ? 1 : 0;
    e_err = ((m_ev & ERRS) != 0) ? 1 : 0;
    cmp("irq R5", int'(irq), e_irq);
    cmp("err_pending R11", int'(err_pending), e_err);
    cmp("done_ok R11", int'(done_ok), ((m_ev & 1) != 0 && e_err == 0) ? 1 : 0);
    cmp("start_pulse R9", int'(start_pulse), int'(m_start));
    cmp("rx_flush R7", int'(rx_flush), int'(m_rxfl));
    cmp("tx_flush R7", int'(tx_flush), int'(m_txfl));
    case (reg_addr)
      2'd0: e_rd = ((m_rxcnt != 0) ? 2 : 0) | ((m_txcnt != 0) ? 4 : 0);
      2'd1: e_rd = m_mask;
      2'd2: e_rd = m_ev;
      default: e_rd = int'(dev_ready) | (int'(subsys_ready) << 1) | (e_irq << 2) |
                      (int'(txf_full) << 3) | (int'(rxf_empty) << 4);
    endcase
    cmp("rdata R10", int'(reg_rdata), e_rd);
  endtask

  task automatic step(input bit w, input int a, input int d, input int p);
    @(negedge clk);
    if (rst_n) compare_all();
    reg_wr = w; reg_addr = 2'(a); reg_wdata = 16'(d); evt_pulse = 9'(p);
  endtask

  task automatic rd(input int a, input int n);
    for (int i = 0; i < n; i++) step(0, a, 0, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1"; rd(1, 1); rd(2, 1); rd(0, 2);
    phase = "R6"; step(0, 2, 0, 'h003); rd(2, 2);
    phase = "R5"; step(1, 1, 'h1FE, 0); rd(3, 2); rd(1, 1);
    phase = "R3"; step(1, 2, 'h001, 0); rd(2, 2);
    phase = "R4"; step(1, 2, 'h002, 'h002); rd(2, 2);
    phase = "R3"; step(1, 2, 'h1FF, 0); rd(2, 2);
    phase = "R11"; step(0, 2, 0, 'h001); rd(2, 2);
    step(0, 2, 0, 'h040); rd(2, 2); step(1, 2, 'h1FF, 0);
    phase = "R7"; step(1, 0, 'h2, 0); rd(0, 4);
    step(1, 0, 'h4, 0); rd(0, 4); step(1, 0, 'h6, 0); rd(0, 4);
    phase = "R8"; step(1, 0, 'h2, 0); step(1, 0, 'h2, 0); step(1, 0, 'h6, 0); rd(0, 4);
    phase = "R9"; step(1, 0, 'h1, 0); rd(0, 2);
    phase = "R12"; step(1, 3, 'hFFFF, 0); rd(1, 1); rd(2, 1); rd(0, 1);
    phase = "R10";
    for (int i = 0; i < 20; i++) begin
      {dev_ready, subsys_ready, txf_full, rxf_empty} = 4'($urandom);
      step(0, 3, 0, (i == 5) ? 'h100 : 0);
    end
    step(1, 1, 'h000, 0); rd(3, 2);
    phase = "R2";
    for (int i = 0; i < 400; i++) begin
      {dev_ready, subsys_ready, txf_full, rxf_empty} = 4'($urandom);
      step(($urandom % 3) == 0, int'($urandom % 4), int'($urandom),
           (($urandom % 4) == 0) ? int'($urandom % 512) : 0);
    end
    rd(2, 1);
    finish_run();
  end
endmodule